// File: doc/BRIEF.md
# Common RAM Address Mapper

This block takes each CPU address and decides which physical RAM block serves it. Normally the block comes from the CPU's selected-block input. A programmable shared window can pin the lowest addresses, the highest addresses, or both, to block 0. Code and data placed in that window then stay reachable whatever bank the CPU has selected. The window size and placement come from one configuration byte held inside the block. The top window applies only while the surrounding decoder reports that RAM is visible at the top of memory.

Two small address holes always belong to hardware registers and are never served by RAM. The mapper flags them on `hw_reg`. The same configuration byte carries a separate block select for video and DMA masters. The shared window never alters that select. Apart from the configuration register, the address path is purely combinational. ROM and I/O overlay decoding belong to the neighbouring decoder.

Top module: `common_ram_mapper`

## Requirements
- R1: Configuration bits 1:0 set the window size: code 0 gives 1 KiB, code 1 gives 4 KiB, code 2 gives 8 KiB, code 3 gives 16 KiB.
- R2: An address that is neither a hardware hole nor inside an active window maps to `phys_blk` equal to `sel_blk`.
- R3: When configuration bit 2 is set, addresses from 0x0000 up to the window size minus one map to block 0.
- R4: When configuration bit 3 is set and `top_ram_vis` is high, addresses from 0x10000 minus the window size up to 0xFFFF map to block 0. With `top_ram_vis` low, the top window has no effect.
- R5: Addresses 0x0000, 0x0001 and 0xFF00 through 0xFF04 drive `hw_reg` high with `phys_blk` 0. All other addresses drive `hw_reg` low.
- R6: `dma_blk` equals configuration bit 6, whatever the window size, placement and CPU address.
- R7: Configuration bits 7, 5 and 4 are stored and read back on `cfg_q`, but they do not change `phys_blk`, `hw_reg` or `dma_blk`.
- R8: After reset the configuration byte reads 0x04. This gives a 1 KiB bottom window at 0x0000 to 0x03FF.
- R9: A write with `cfg_we` high is captured at the rising clock edge. From that edge on, `cfg_q` and the mapping follow the new value with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to store |
| cfg_q | output | 8 | Current configuration byte |
| cpu_addr | input | ADDR_W (16) | CPU address |
| sel_blk | input | BLK_W (1) | RAM block selected by the CPU bank setting |
| top_ram_vis | input | 1 | RAM is visible at the top of memory |
| hw_reg | output | 1 | Address falls in a hardware-register hole |
| phys_blk | output | BLK_W (1) | Physical RAM block for the CPU access |
| dma_blk | output | BLK_W (1) | RAM block for video and DMA accesses |

## Verification
The bench builds the block with its defaults: a 16-bit address and a one-bit block number. At this size every combination of size code, placement, selected block and top-visibility flag can be swept. For each combination the bench walks every 256-byte page of the address space. On each page it probes offsets that sit on window edges and hole edges, including 0x03FF/0x0400, 0xFBFF/0xFC00 and 0xFF04/0xFF05. The upper configuration nibble changes with every combination. This shows that the DMA select follows bit 6 alone and that the stored spare bits never reach the mapping.

// File: rtl/cram_pkg.sv
package cram_pkg;

  typedef enum logic [1:0] {
    PLC_NONE = 2'b00,
    PLC_BOT  = 2'b01,
    PLC_TOP  = 2'b10,
    PLC_BOTH = 2'b11
  } place_e;

  // log2 of the shared window size for a 2-bit size code
  function automatic int unsigned win_log2(input logic [1:0] code, input int unsigned min_log);
    case (code)
      2'd0:    return min_log;
      2'd1:    return min_log + 2;
      2'd2:    return min_log + 3;
      default: return min_log + 4;
    endcase
  endfunction

endpackage

// File: rtl/cram_cfg_reg.sv
module cram_cfg_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end
endmodule

// File: rtl/cram_window_dec.sv
module cram_window_dec
  import cram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned MIN_LOG = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_code,
  input  logic [1:0]        place,
  input  logic              top_vis,
  output logic              hit
);
  logic [ADDR_W-1:0] upper_mask;
  logic [1:0]        end_hit;
  logic [1:0]        end_en;

  always_comb begin
    upper_mask = ~((ADDR_W'(1) << win_log2(size_code, MIN_LOG)) - ADDR_W'(1));
  end

  // end 0: bottom window (upper bits all zero); end 1: top window (all one)
  for (genvar e = 0; e < 2; e++) begin : g_end
    if (e == 0) begin : g_bot
      assign end_hit[e] = ((addr & upper_mask) == '0);
      assign end_en[e]  = place[0];
    end else begin : g_top
      assign end_hit[e] = ((addr & upper_mask) == upper_mask);
      assign end_en[e]  = place[1] & top_vis;
    end
  end

  assign hit = |(end_hit & end_en);
endmodule

// File: rtl/cram_hole_det.sv
module cram_hole_det #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned LO_CNT  = 2,
  parameter int unsigned HI_BASE = 16'hFF00,
  parameter int unsigned HI_CNT  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hole
);
  localparam logic [ADDR_W-1:0] LO_END  = ADDR_W'(LO_CNT);
  localparam logic [ADDR_W-1:0] HI_LO   = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] HI_LAST = ADDR_W'(HI_BASE + HI_CNT - 1);

  always_comb begin
    hole = (addr < LO_END) || ((addr >= HI_LO) && (addr <= HI_LAST));
  end
endmodule

// File: rtl/common_ram_mapper.sv
module common_ram_mapper
  import cram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BLK_W   = 1,
  parameter int unsigned MIN_LOG = 10,
  parameter logic [7:0]  CFG_RST = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_q,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BLK_W-1:0]  sel_blk,
  input  logic              top_ram_vis,
  output logic              hw_reg,
  output logic [BLK_W-1:0]  phys_blk,
  output logic [BLK_W-1:0]  dma_blk
);
  localparam int unsigned DMA_LSB = 6;

  logic win_hit;
  logic hole;

  cram_cfg_reg #(.W(8), .RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  cram_window_dec #(.ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG)) u_win (
    .addr(cpu_addr), .size_code(cfg_q[1:0]), .place(cfg_q[3:2]),
    .top_vis(top_ram_vis), .hit(win_hit)
  );

  cram_hole_det #(.ADDR_W(ADDR_W)) u_hole (
    .addr(cpu_addr), .hole(hole)
  );

  always_comb begin
    hw_reg   = hole;
    phys_blk = (hole || win_hit) ? '0 : sel_blk;
    dma_blk  = cfg_q[DMA_LSB +: BLK_W];
  end

  // R5
  hole_blk0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reg |-> (phys_blk == '0));

  // R5
  lo_hole_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == '0) |-> hw_reg);

  // R2
  no_window_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_reg && (phys_blk != sel_blk)) |-> (cfg_q[3:2] != 2'b00));

  // R4
  top_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[3:2] == 2'b10 && !top_ram_vis && !hw_reg) |-> (phys_blk == sel_blk));

  // R9
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));

  // R6
  dma_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[DMA_LSB] == cfg_q[DMA_LSB])) |=> $stable(dma_blk));
endmodule

// File: tb/tb_common_ram_mapper.sv
module tb_common_ram_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_q;
  logic [15:0] cpu_addr;
  logic [0:0]  sel_blk;
  logic        top_ram_vis;
  logic        hw_reg;
  logic [0:0]  phys_blk;
  logic [0:0]  dma_blk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  common_ram_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .cpu_addr(cpu_addr), .sel_blk(sel_blk), .top_ram_vis(top_ram_vis),
    .hw_reg(hw_reg), .phys_blk(phys_blk), .dma_blk(dma_blk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %04h cfg %02h)", req, act, exp, cpu_addr, cfg_q);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  function automatic int unsigned win_size(input int unsigned code);
    case (code)
      0: return 1024;
      1: return 4096;
      2: return 8192;
      default: return 16384;
    endcase
  endfunction

  initial begin : main
    int unsigned offs [6] = '{0, 1, 2, 4, 5, 255};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cpu_addr = '0; sel_blk = 1'b1; top_ram_vis = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset cfg", int'(cfg_q), 'h04);
    cpu_addr = 16'h03FF; #1 chk("R8 reset window 03FF", int'(phys_blk), 0);
    cpu_addr = 16'h0400; #1 chk("R8 reset window 0400", int'(phys_blk), 1);
    chk("R6 reset dma", int'(dma_blk), 0);

    // R9: new value visible right after the capturing edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h45; cpu_addr = 16'h0FFF;
    #1 chk("R9 before edge", int'(phys_blk), 1);
    @(posedge clk); #1 cfg_we = 1'b0;
    chk("R9 cfg_q after edge", int'(cfg_q), 'h45);
    chk("R9 mapping after edge", int'(phys_blk), 0);
    chk("R6 dma after edge", int'(dma_blk), 1);

    // R7 readback of spare bits
    write_cfg(8'hB0);
    chk("R7 readback B0", int'(cfg_q), 'hB0);
    chk("R6 bit7 only", int'(dma_blk), 0);

    // Sweep: R1 R2 R3 R4 R5 R6 R7
    for (int lo = 0; lo < 16; lo++) begin
      logic [3:0] hi;
      logic [7:0] cv;
      hi = 4'(lo) ^ 4'hA;
      cv = {hi, 4'(lo)};
      write_cfg(cv);
      chk("R7 readback sweep", int'(cfg_q), int'(cv));
      for (int s = 0; s < 2; s++) begin
        for (int tv = 0; tv < 2; tv++) begin
          @(negedge clk);
          sel_blk = 1'(s); top_ram_vis = 1'(tv);
          for (int pg = 0; pg < 256; pg++) begin
            for (int k = 0; k < 6; k++) begin
              int unsigned a, sz;
              bit hole, bot, top;
              int exp_blk;
              string req;
              a = pg * 256 + offs[k];
              sz = win_size(lo % 4);
              hole = (a < 2) || (a >= 'hFF00 && a <= 'hFF04);
              bot = ((lo / 4) % 2 == 1) && (a < sz);
              top = (lo / 8 == 1) && (tv == 1) && (a >= 65536 - sz);
              exp_blk = (hole || bot || top) ? 0 : s;
              if (hole) req = "R5";
              else if (bot) req = "R3 R1";
              else if (top) req = "R4 R1";
              else req = "R2 R7";
              cpu_addr = 16'(a);
              #1;
              chk(req, int'(phys_blk), exp_blk);
              chk("R5 flag", int'(hw_reg), int'(hole));
              chk("R6 dma", int'(dma_blk), int'(hi[2]));
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule